// File: doc/BRIEF.md
# Mode-Dependent Reset Boot Sequencer

This block brings an 8-bit microcontroller core out of reset. While reset is held, it puts a small set of on-chip control registers into their power-on values. On the first clock after reset is released, it captures the two operating-mode pins into a mode register and picks where the core will start executing. It then hands the core its initial program counter and condition code byte, and marks the hand-off with a one-cycle start pulse.

The start address comes from one of three sources. In the vector modes it is a big-endian 16-bit word, read one byte at a time over a byte-wide request/valid read port. In the bootstrap mode no read is made and the address is zero. When the override-enable input is set, a preloaded address is used and the mode pins have no say. After the start pulse, a cycle counter runs for the core.

Top module: `boot_sequencer`

## Requirements
- R1: While rst_ni is low: start_o=0, mem_req_o=0, pc_o=0, init_o=8'h01, arch_o=0, cyc_o=0, every 16-bit field of oc_cmp_o is 16'hFFFF, and cfg_o=4'hF. The cfg_o fields are bit3 security off, bit2 watchdog off, bit1 EEPROM on and bit0 ROM on.
- R2: On the first clock after reset is released, mode_o captures the pins: bit1 = mode_special_i, bit0 = mode_a_i, bits 7:2 = 0. It keeps that value until the next reset, whatever the pins do.
- R3: With mode_special_i=0, or with both mode pins set, and no override, exactly two reads are made. The first is at 16'hFFFE and returns the high byte; the second is at 16'hFFFF and returns the low byte. pc_o = {high, low}.
- R4: With mode_special_i=1, mode_a_i=0 and no override, no read request is raised and pc_o=16'h0000 at start.
- R5: If ovr_en_i is high on the first clock after reset release, pc_o=ovr_addr_i at start and no read request is raised, in any mode.
- R6: ccr_o is 8'hD0: bit7 stop-disable, bit6 X-interrupt mask and bit4 I-interrupt mask are set, and all other bits are clear.
- R7: mem_req_o and mem_addr_o hold steady until mem_vld_i is seen, for any number of wait cycles. start_o is high for exactly one cycle, and pc_o is valid in that cycle.
- R8: cyc_o is 0 through the start cycle, then rises by one on each clock.
- R9: pc_o does not change after the start pulse until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_special_i | input | 1 | Special-mode pin |
| mode_a_i | input | 1 | Mode-A pin |
| ovr_en_i | input | 1 | Use ovr_addr_i as the start address |
| ovr_addr_i | input | 16 | Preloaded start address |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | 16 | Read address |
| mem_vld_i | input | 1 | Read data valid |
| mem_data_i | input | 8 | Read data |
| mode_o | output | 8 | Captured mode register |
| init_o | output | 8 | Register-init register |
| cfg_o | output | 4 | Configuration word |
| oc_cmp_o | output | 64 | Four output-compare registers, channel 1 in bits 15:0 |
| arch_o | output | 64 | {D, X, Y, SP} core registers |
| cyc_o | output | 16 | Cycle counter |
| pc_o | output | 16 | Initial program counter |
| ccr_o | output | 8 | Initial condition code register |
| start_o | output | 1 | One-cycle start pulse |

## Verification
The bench runs all four mode-pin combinations. A design that decoded bootstrap wrongly would either issue reads or start at the fetched vector. Override is tried in both a vector mode and bootstrap, so a design that let the mode win would show reads or a wrong pc_o. Memory latencies of zero to three cycles expose byte order or address mistakes: a design that advanced without valid would capture stale bytes, and one with swapped halves would give a byte-reversed pc_o. The mode pins and override are also toggled after start, which catches a mode register or pc_o that keeps tracking the inputs.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [1:0] {SRC_VEC, SRC_ZERO, SRC_OVR} boot_src_e;
  typedef enum logic [2:0] {ST_LATCH, ST_HI, ST_LO, ST_GO, ST_RUN} boot_st_e;
  localparam logic [7:0] CCR_BOOT = 8'hD0;  // stop-disable, X mask, I mask
  localparam logic [7:0] INIT_RST = 8'h01;
endpackage

// File: rtl/boot_mode_dec.sv
module boot_mode_dec
  import boot_pkg::*;
(
  input  logic      special_i,
  input  logic      mode_a_i,
  input  logic      ovr_en_i,
  output boot_src_e src_o
);
  always_comb begin
    if (ovr_en_i)                  src_o = SRC_OVR;
    else if (special_i && !mode_a_i) src_o = SRC_ZERO;
    else                           src_o = SRC_VEC;
  end
endmodule

// File: rtl/boot_vec_fetch.sv
module boot_vec_fetch
  import boot_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFFFE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  boot_src_e     src_i,
  input  logic [1:0]    mode_pins_i,
  input  logic [AW-1:0] ovr_addr_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_vld_i,
  input  logic [DW-1:0] mem_data_i,
  output logic [1:0]    mode_q_o,
  output logic [AW-1:0] pc_o,
  output logic          start_o,
  output logic          run_o
);
  localparam logic [AW-1:0] VEC_LO = VEC_ADDR + AW'(1);

  boot_st_e      st_q;
  logic [AW-1:0] pc_q;
  logic [1:0]    mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_LATCH;
      pc_q   <= '0;
      mode_q <= '0;
    end else begin
      unique case (st_q)
        ST_LATCH: begin
          mode_q <= mode_pins_i;
          unique case (src_i)
            SRC_OVR:  begin pc_q <= ovr_addr_i; st_q <= ST_GO; end
            SRC_ZERO: begin pc_q <= '0;         st_q <= ST_GO; end
            default:  st_q <= ST_HI;
          endcase
        end
        ST_HI: if (mem_vld_i) begin
          pc_q[AW-1 -: DW] <= mem_data_i;
          st_q <= ST_LO;
        end
        ST_LO: if (mem_vld_i) begin
          pc_q[DW-1:0] <= mem_data_i;
          st_q <= ST_GO;
        end
        ST_GO:   st_q <= ST_RUN;
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign mem_req_o  = (st_q == ST_HI) || (st_q == ST_LO);
  assign mem_addr_o = (st_q == ST_LO) ? VEC_LO : VEC_ADDR;
  assign start_o    = (st_q == ST_GO);
  assign run_o      = (st_q == ST_RUN);
  assign pc_o       = pc_q;
  assign mode_q_o   = mode_q;
endmodule

// File: rtl/boot_reg_defaults.sv
module boot_reg_defaults
  import boot_pkg::*;
#(
  parameter int unsigned NUM_OC = 4,
  parameter int unsigned OC_W   = 16,
  parameter int unsigned ARCH_N = 4,
  parameter int unsigned ARCH_W = 16,
  parameter int unsigned CFG_W  = 4,
  parameter logic [CFG_W-1:0] CFG_RST = 4'hF,
  parameter int unsigned CYC_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     count_i,
  output logic [NUM_OC*OC_W-1:0]   oc_o,
  output logic [ARCH_N*ARCH_W-1:0] arch_o,
  output logic [7:0]               init_o,
  output logic [CFG_W-1:0]         cfg_o,
  output logic [7:0]               ccr_o,
  output logic [CYC_W-1:0]         cyc_o
);
  for (genvar g = 0; g < NUM_OC; g++) begin : g_oc
    logic [OC_W-1:0] oc_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) oc_q <= '1;
      else         oc_q <= oc_q;
    assign oc_o[g*OC_W +: OC_W] = oc_q;
  end

  for (genvar g = 0; g < ARCH_N; g++) begin : g_arch
    logic [ARCH_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) r_q <= '0;
      else         r_q <= r_q;
    assign arch_o[g*ARCH_W +: ARCH_W] = r_q;
  end

  logic [7:0]       init_q, ccr_q;
  logic [CFG_W-1:0] cfg_q;
  logic [CYC_W-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= INIT_RST;
      ccr_q  <= CCR_BOOT;
      cfg_q  <= CFG_RST;
      cyc_q  <= '0;
    end else begin
      if (count_i) cyc_q <= cyc_q + CYC_W'(1);
    end
  end

  assign init_o = init_q;
  assign ccr_o  = ccr_q;
  assign cfg_o  = cfg_q;
  assign cyc_o  = cyc_q;
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
  import boot_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 8,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFFFE,
  parameter int unsigned NUM_OC = 4,
  parameter int unsigned OC_W   = 16,
  parameter int unsigned CFG_W  = 4,
  parameter logic [CFG_W-1:0] CFG_RST = 4'hF,
  parameter int unsigned CYC_W  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mode_special_i,
  input  logic                   mode_a_i,
  input  logic                   ovr_en_i,
  input  logic [AW-1:0]          ovr_addr_i,
  output logic                   mem_req_o,
  output logic [AW-1:0]          mem_addr_o,
  input  logic                   mem_vld_i,
  input  logic [DW-1:0]          mem_data_i,
  output logic [7:0]             mode_o,
  output logic [7:0]             init_o,
  output logic [CFG_W-1:0]       cfg_o,
  output logic [NUM_OC*OC_W-1:0] oc_cmp_o,
  output logic [4*AW-1:0]        arch_o,
  output logic [CYC_W-1:0]       cyc_o,
  output logic [AW-1:0]          pc_o,
  output logic [7:0]             ccr_o,
  output logic                   start_o
);
  boot_src_e src;
  logic [1:0] mode_q;
  logic run;

  boot_mode_dec i_dec (
    .special_i (mode_special_i),
    .mode_a_i  (mode_a_i),
    .ovr_en_i  (ovr_en_i),
    .src_o     (src)
  );

  boot_vec_fetch #(.AW(AW), .DW(DW), .VEC_ADDR(VEC_ADDR)) i_fetch (
    .clk_i, .rst_ni,
    .src_i       (src),
    .mode_pins_i ({mode_special_i, mode_a_i}),
    .ovr_addr_i,
    .mem_req_o, .mem_addr_o, .mem_vld_i, .mem_data_i,
    .mode_q_o    (mode_q),
    .pc_o, .start_o,
    .run_o       (run)
  );

  boot_reg_defaults #(
    .NUM_OC(NUM_OC), .OC_W(OC_W), .ARCH_N(4), .ARCH_W(AW),
    .CFG_W(CFG_W), .CFG_RST(CFG_RST), .CYC_W(CYC_W)
  ) i_defs (
    .clk_i, .rst_ni,
    .count_i (start_o | run),
    .oc_o    (oc_cmp_o),
    .arch_o,
    .init_o, .cfg_o, .ccr_o, .cyc_o
  );

  assign mode_o = {6'b0, mode_q};
endmodule

// File: rtl/boot_sequencer_chk.sv
module boot_sequencer_chk #(
  parameter int unsigned AW    = 16,
  parameter int unsigned CYC_W = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_o,
  input logic [AW-1:0] pc_o,
  input logic [7:0]    mode_o,
  input logic          mem_req_o,
  input logic          mem_vld_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [CYC_W-1:0] cyc_o
);
  logic seen_start;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      seen_start <= 1'b0;
    else if (start_o) seen_start <= 1'b1;

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_vld_i |=> mem_req_o && $stable(mem_addr_o));
  // R7
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R7
  no_req_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !mem_req_o);
  // R9
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_start |-> $stable(pc_o));
  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_start |-> $stable(mode_o));
  // R3
  vec_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[AW-1:1] == {(AW-1){1'b1}}));
  // R8
  cyc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_start |-> (cyc_o == '0));
endmodule

bind boot_sequencer boot_sequencer_chk #(.AW(AW), .CYC_W(CYC_W)) i_chk (
  .clk_i, .rst_ni, .start_o, .pc_o, .mode_o,
  .mem_req_o, .mem_vld_i, .mem_addr_o, .cyc_o
);

// File: tb/test_boot_sequencer.sv
module test_boot_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_ni = 0;
  logic sp = 0, ma = 0, oen = 0;
  logic [15:0] oaddr = 0;
  logic mem_req, mem_vld = 0;
  logic [15:0] mem_addr;
  logic [7:0] mem_data = 0;
  logic [7:0] mode, init, ccr;
  logic [3:0] cfg;
  logic [63:0] oc, arch;
  logic [15:0] cyc, pc;
  logic start;

  int errors = 0, checks = 0;
  int lat = 0, wait_cnt = 0, nrd = 0, req_cyc = 0;
  logic [7:0] vhi = 0, vlo = 0;
  logic [15:0] rd_addr [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_sequencer i_boot_sequencer (
    .clk_i(clk), .rst_ni, .mode_special_i(sp), .mode_a_i(ma),
    .ovr_en_i(oen), .ovr_addr_i(oaddr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_vld_i(mem_vld), .mem_data_i(mem_data),
    .mode_o(mode), .init_o(init), .cfg_o(cfg), .oc_cmp_o(oc), .arch_o(arch),
    .cyc_o(cyc), .pc_o(pc), .ccr_o(ccr), .start_o(start)
  );

  // memory responder with programmable latency
  initial forever begin
    @(negedge clk);
    if (mem_req) begin
      req_cyc++;
      if (wait_cnt >= lat) begin
        mem_vld  = 1;
        mem_data = (mem_addr == 16'hFFFE) ? vhi : vlo;
        if (nrd < 2) rd_addr[nrd] = mem_addr;
        nrd++;
        wait_cnt = 0;
      end else begin
        mem_vld = 0;
        wait_cnt++;
      end
    end else begin
      mem_vld = 0;
      wait_cnt = 0;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic boot(input logic s, input logic a, input logic oe, input logic [15:0] oa,
                      input logic [15:0] vec, input int l, input logic [15:0] exp_pc,
                      input int exp_rd, string tag);
    int n = 0;
    @(negedge clk);
    rst_ni = 0;
    sp = s; ma = a; oen = oe; oaddr = oa;
    vhi = vec[15:8]; vlo = vec[7:0]; lat = l;
    nrd = 0; req_cyc = 0;
    rd_addr[0] = 0; rd_addr[1] = 0;
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    sp = ~s; ma = ~a; oen = ~oe;  // pins after capture must not matter
    while (!start && n < 50) begin @(negedge clk); n++; end
    check({tag, " R7 start seen"}, 64'(start), 64'd1);
    check({tag, " pc R3/R4/R5"}, 64'(pc), 64'(exp_pc));
    check({tag, " R6 ccr"}, 64'(ccr), 64'hD0);
    check({tag, " R2 mode"}, 64'(mode), 64'({s, a}));
    check({tag, " R8 cyc at start"}, 64'(cyc), 64'd0);
    if (exp_rd == 0) check({tag, " R4/R5 no request"}, 64'(req_cyc), 64'd0);
    else begin
      check({tag, " R3 reads"}, 64'(nrd), 64'd2);
      check({tag, " R3 first addr"}, 64'(rd_addr[0]), 64'hFFFE);
      check({tag, " R3 second addr"}, 64'(rd_addr[1]), 64'hFFFF);
      check({tag, " R7 wait cycles"}, 64'(req_cyc), 64'(2*(l+1)));
    end
    @(negedge clk);
    check({tag, " R7 pulse one cycle"}, 64'(start), 64'd0);
    check({tag, " R8 cyc step"}, 64'(cyc), 64'd1);
    sp = s; ma = a; oen = oe; oaddr = ~oa;
    @(negedge clk);
    @(negedge clk);
    check({tag, " R8 cyc count"}, 64'(cyc), 64'd3);
    check({tag, " R9 pc held"}, 64'(pc), 64'(exp_pc));
    check({tag, " R2 mode held"}, 64'(mode), 64'({s, a}));
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_ni = 0;
    @(negedge clk);
    check("R1 start", 64'(start), 0);
    check("R1 req", 64'(mem_req), 0);
    check("R1 pc", 64'(pc), 0);
    check("R1 init", 64'(init), 64'h01);
    check("R1 cfg", 64'(cfg), 64'hF);
    check("R1 oc", oc, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R1 arch", arch, 0);
    check("R1 cyc", 64'(cyc), 0);
    check("R6 ccr in reset", 64'(ccr), 64'hD0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    boot(0, 0, 0, 16'h0000, 16'hABCD, 0, 16'hABCD, 2, "single");
    boot(0, 1, 0, 16'h0000, 16'h1234, 3, 16'h1234, 2, "expanded");
    boot(1, 1, 0, 16'h0000, 16'h8001, 1, 16'h8001, 2, "test");
    boot(1, 0, 0, 16'h0000, 16'hBEEF, 0, 16'h0000, 0, "bootstrap");
    boot(0, 0, 1, 16'h5A5A, 16'h1111, 0, 16'h5A5A, 0, "ovr_vec");
    boot(1, 0, 1, 16'hC3C3, 16'h2222, 0, 16'hC3C3, 0, "ovr_boot");
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule